// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

This block holds eight match channels, numbered 4 to 11 in software terms and 0 to 7 inside the design. Each channel has a counter, a match value and a control word. A channel counts on ticks from one of eight tick sources. It can compare its match value against its own counter or against the counter of a base channel in its group. When the compared counter steps onto the match value, the channel raises its status bit if that bit is enabled. All status bits feed one shared interrupt line.

Each counter advances on a one-cycle tick-enable taken from the `tick_src` input. This input takes the place of real clock dividers. The parameter `SRC_LIVE` marks the table entries that have no clock, and a counter that selects such an entry never moves. Two channels can take a copy of the counter next to them when software reads their own counter. The register port is a plain synchronous port. It accepts a read or a write every cycle and has no back-pressure. Read data appears on `rdata` one cycle after `rd_en` and is held until the next read.

Top module: `mtb_top`

## Requirements
- R1: After reset every match, counter, control, status, enable and snapshot register reads 0, all channels select tick source 0, no channel is armed, `irq` is low and `rdata` is 0.
- R2: A counter increments by one, wrapping to 0 after its maximum, in each cycle where `tick_src[sel]` is high and `SRC_LIVE[sel]` is 1. Here `sel` is the channel's current source. With `SRC_LIVE[sel]` = 0 the counter never moves.
- R3: With control bit 7 set, a channel compares its match value against its own counter. With bit 7 clear it compares against a base counter: channels 4 to 7 use channel 4, channels 8 and 9 use channel 8, and channels 10 and 11 use channel 10. A match event occurs when an armed channel's compared counter takes a tick that makes its next value equal the match value.
- R4: A control write copies bits 2:0 into the channel's source select only if the written bit 7 is 1 or the channel is a base channel (4, 8 or 10). Otherwise the source select is left unchanged.
- R5: With control bit 3 set, a match event of a channel that compares against its own counter loads that counter with 0 in place of the match value.
- R6: Writing a match register arms the channel. With control bit 6 set the channel stays armed after an event, so it fires each time. With bit 6 clear the event disarms it.
- R7: Control registers of channels 4 to 7 keep bits 7:0 and read bits 9:8 as 0. Channels 8 to 11 keep bits 9:0.
- R8: On channels 8 to 11, a control write with bit 8 set (and bit 7 set or a base channel) selects source 0 whatever bits 2:0 hold.
- R9: A read of the counter of channel 9 or 11 while its control bit 9 is set copies the counter of channel 8 or 10, as it stood in that cycle, into the snapshot register. The snapshot changes at no other time.
- R10: A match event sets its status bit only if the matching enable bit is 1. Writing the status register clears every bit written as 1. An event in the same cycle wins over the clear.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: Writing a counter register loads it in the next cycle, and the write takes priority over a tick in that cycle. A tick that coincides with a load of the compared counter is dropped and raises no event.
- R13: Word addresses: 0 to 7 are match values, 8 to 15 are counters, 16 to 23 are control words, 24 is status, 25 is enable, and 26 is the read-only snapshot. Reads of 27 to 31 return 0 and writes to them, or to 26, change nothing.
- R14: A control write takes effect from the following cycle. A tick or event in the write cycle uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| tick_src | input | 8 | One-cycle tick enables, one per source table entry |
| rdata | output | 32 | Read data, valid the cycle after `rd_en`, held until the next read |
| irq | output | 1 | Shared interrupt, OR of the status bits |

## Verification
The bench builds the bank with 32-bit counters and `SRC_LIVE` = 8'b1101_1111. Entry 5 has no clock, so the stopped-counter case can be reached by selecting that entry. Counters can be loaded close to all-ones, so wrap-around shows up within a few ticks. A long stretch of pseudo-random register traffic uses small match and counter values, which makes shared-counter matches, periodic reloads and snapshot captures happen often.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int NCH  = 8;
  localparam int NSRC = 8;
  localparam int AW   = 5;
  localparam int CTLW = 10;

  typedef enum logic [1:0] {
    RG_MATCH = 2'd0,
    RG_COUNT = 2'd1,
    RG_CTRL  = 2'd2,
    RG_MISC  = 2'd3
  } region_e;

  localparam logic [2:0] MISC_STAT = 3'd0;
  localparam logic [2:0] MISC_EN   = 3'd1;
  localparam logic [2:0] MISC_SNAP = 3'd2;

  // base counter index of a channel when it does not own its counter
  function automatic int base_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction

  function automatic logic [CTLW-1:0] ctrl_mask(input int idx);
    return (idx < 4) ? 10'h0FF : 10'h3FF;
  endfunction
endpackage

// File: rtl/mtb_lane.sv
module mtb_lane
  import mtb_pkg::*;
#(
  parameter int              IDX      = 0,
  parameter int              CNT_W    = 32,
  parameter logic [NSRC-1:0] SRC_LIVE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_src,
  input  logic             wr_match,
  input  logic             wr_count,
  input  logic             wr_ctrl,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cmp_cnt,
  input  logic             cmp_tick,
  input  logic             cmp_load,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] match_q,
  output logic [CTLW-1:0]  ctrl_q,
  output logic [2:0]       sel_q,
  output logic             own_tick,
  output logic             hit
);
  localparam bit              IS_BASE = (base_of(IDX) == IDX);
  localparam logic [CTLW-1:0] MASK    = ctrl_mask(IDX);

  logic             armed_q;
  logic             force_zero;
  logic             sel_take;
  logic             self_cmp;
  logic [2:0]       sel_new;
  logic [CNT_W-1:0] cmp_next;
  logic [CNT_W-1:0] cnt_step;

  // upper group honours the force-source-0 bit, lower group has no such bit
  generate
    if (IDX >= 4) begin : g_ext
      assign force_zero = wdata[8];
    end else begin : g_std
      assign force_zero = 1'b0;
    end
  endgenerate

  assign sel_take = wr_ctrl && (wdata[7] || IS_BASE);
  assign sel_new  = force_zero ? 3'd0 : wdata[2:0];
  assign own_tick = tick_src[sel_q] & SRC_LIVE[sel_q];
  assign self_cmp = ctrl_q[7] || IS_BASE;
  assign cmp_next = cmp_cnt + CNT_W'(1);
  assign hit      = armed_q && cmp_tick && !cmp_load && (cmp_next == match_q);
  assign cnt_step = (hit && self_cmp && ctrl_q[3]) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      sel_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_count)      cnt_q <= wdata[CNT_W-1:0];
      else if (own_tick) cnt_q <= cnt_step;

      if (wr_match) match_q <= wdata[CNT_W-1:0];

      if (wr_ctrl)  ctrl_q <= wdata[CTLW-1:0] & MASK;
      if (sel_take) sel_q  <= sel_new;

      if (wr_match)              armed_q <= 1'b1;
      else if (hit && !ctrl_q[6]) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mtb_status.sv
module mtb_status
  import mtb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           wr_stat,
  input  logic           wr_enable,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] status_q,
  output logic [NCH-1:0] enable_q,
  output logic           irq
);
  logic [NCH-1:0] kept;

  assign kept = wr_stat ? (status_q & ~wbits) : status_q;
  assign irq  = |status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= kept | (hit & enable_q);
      if (wr_enable) enable_q <= wbits;
    end
  end
endmodule

// File: rtl/mtb_regport.sv
module mtb_regport
  import mtb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 addr,
  input  logic [NCH-1:0][CNT_W-1:0]     match_q,
  input  logic [NCH-1:0][CNT_W-1:0]     cnt_q,
  input  logic [NCH-1:0][CTLW-1:0]      ctrl_q,
  input  logic [NCH-1:0]                status_q,
  input  logic [NCH-1:0]                enable_q,
  output logic [31:0]                   rdata,
  output logic [CNT_W-1:0]              snap_q
);
  region_e    rgn;
  logic [2:0] sub;
  logic [31:0] rd_val;
  logic        capture;

  assign rgn = region_e'(addr[AW-1:3]);
  assign sub = addr[2:0];

  always_comb begin
    rd_val = '0;
    unique case (rgn)
      RG_MATCH: rd_val = 32'(match_q[sub]);
      RG_COUNT: rd_val = 32'(cnt_q[sub]);
      RG_CTRL:  rd_val = 32'(ctrl_q[sub]);
      RG_MISC: begin
        if (sub == MISC_STAT)      rd_val = 32'(status_q);
        else if (sub == MISC_EN)   rd_val = 32'(enable_q);
        else if (sub == MISC_SNAP) rd_val = 32'(snap_q);
      end
      default: rd_val = '0;
    endcase
  end

  // only the odd channels of the upper group capture their neighbour
  assign capture = rd_en && (rgn == RG_COUNT) &&
                   (((sub == 3'd5) && ctrl_q[5][9]) || ((sub == 3'd7) && ctrl_q[7][9]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      snap_q <= '0;
    end else begin
      if (rd_en)   rdata  <= rd_val;
      if (capture) snap_q <= cnt_q[sub - 3'd1];
    end
  end
endmodule

// File: rtl/mtb_top.sv
module mtb_top
  import mtb_pkg::*;
#(
  parameter int              CNT_W    = 32,
  parameter logic [NSRC-1:0] SRC_LIVE = 8'b1101_1111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  input  logic [NSRC-1:0] tick_src,
  output logic [31:0]     rdata,
  output logic            irq
);
  region_e    rgn;
  logic [2:0] sub;

  logic [NCH-1:0][CNT_W-1:0] cnt_q;
  logic [NCH-1:0][CNT_W-1:0] match_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_cnt;
  logic [NCH-1:0][CTLW-1:0]  ctrl_q;
  logic [NCH-1:0][2:0]       sel_q;
  logic [NCH-1:0]            own_tick, cmp_tick, cmp_load, hit;
  logic [NCH-1:0]            wr_match_v, wr_count_v, wr_ctrl_v;
  logic [NCH-1:0]            status_q, enable_q;
  logic [CNT_W-1:0]          snap_q;
  logic                      wr_stat, wr_enable;

  assign rgn       = region_e'(addr[AW-1:3]);
  assign sub       = addr[2:0];
  assign wr_stat   = wr_en && (rgn == RG_MISC) && (sub == MISC_STAT);
  assign wr_enable = wr_en && (rgn == RG_MISC) && (sub == MISC_EN);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_lane
      localparam int BASE = base_of(g);

      assign wr_match_v[g] = wr_en && (rgn == RG_MATCH) && (sub == 3'(g));
      assign wr_count_v[g] = wr_en && (rgn == RG_COUNT) && (sub == 3'(g));
      assign wr_ctrl_v[g]  = wr_en && (rgn == RG_CTRL)  && (sub == 3'(g));

      assign cmp_cnt[g]  = ctrl_q[g][7] ? cnt_q[g]      : cnt_q[BASE];
      assign cmp_tick[g] = ctrl_q[g][7] ? own_tick[g]   : own_tick[BASE];
      assign cmp_load[g] = ctrl_q[g][7] ? wr_count_v[g] : wr_count_v[BASE];

      mtb_lane #(
        .IDX      (g),
        .CNT_W    (CNT_W),
        .SRC_LIVE (SRC_LIVE)
      ) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_src (tick_src),
        .wr_match (wr_match_v[g]),
        .wr_count (wr_count_v[g]),
        .wr_ctrl  (wr_ctrl_v[g]),
        .wdata    (wdata),
        .cmp_cnt  (cmp_cnt[g]),
        .cmp_tick (cmp_tick[g]),
        .cmp_load (cmp_load[g]),
        .cnt_q    (cnt_q[g]),
        .match_q  (match_q[g]),
        .ctrl_q   (ctrl_q[g]),
        .sel_q    (sel_q[g]),
        .own_tick (own_tick[g]),
        .hit      (hit[g])
      );
    end
  endgenerate

  mtb_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .wr_stat   (wr_stat),
    .wr_enable (wr_enable),
    .wbits     (wdata[NCH-1:0]),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .irq       (irq)
  );

  mtb_regport #(.CNT_W(CNT_W)) u_regport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .match_q  (match_q),
    .cnt_q    (cnt_q),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .enable_q (enable_q),
    .rdata    (rdata),
    .snap_q   (snap_q)
  );
endmodule

// File: rtl/mtb_chk.sv
module mtb_chk
  import mtb_pkg::*;
#(
  parameter int              CNT_W    = 32,
  parameter logic [NSRC-1:0] SRC_LIVE = '1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [AW-1:0]             addr,
  input logic [31:0]               wdata,
  input logic                      irq,
  input logic [NCH-1:0][CNT_W-1:0] cnt_q,
  input logic [NCH-1:0][2:0]       sel_q,
  input logic [NCH-1:0]            status_q,
  input logic [NCH-1:0]            enable_q,
  input logic [CNT_W-1:0]          snap_q
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(24);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      // R12: a counter write is visible the next cycle
      p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(8 + g)) |=> (cnt_q[g] == $past(wdata[CNT_W-1:0])));

      // R2: a counter on a source without clock never moves
      p_dead_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!SRC_LIVE[sel_q[g]] && !(wr_en && addr == AW'(8 + g))) |=> $stable(cnt_q[g]));
    end
  endgenerate

  // R10: a newly set status bit had its enable set
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

  // R11: the shared line only drops through a status write
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == STAT_ADDR)) |=> irq);

  // R9: the snapshot only changes on a read
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(snap_q));
endmodule

bind mtb_top mtb_chk #(
  .CNT_W    (CNT_W),
  .SRC_LIVE (SRC_LIVE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .irq      (irq),
  .cnt_q    (cnt_q),
  .sel_q    (sel_q),
  .status_q (status_q),
  .enable_q (enable_q),
  .snap_q   (snap_q)
);

// File: tb/tb_mtb_top.sv
`timescale 1ns/1ps
module tb_mtb_top;
  localparam logic [7:0] LIVE = 8'b1101_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  tick_src = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  mtb_top #(.CNT_W(32), .SRC_LIVE(LIVE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick_src(tick_src), .rdata(rdata), .irq(irq)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  logic [7:0]  tmask = '0;
  bit          rnd_t = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  // behavioural reference state
  logic [31:0] m_match [8];
  logic [31:0] m_cnt   [8];
  logic [31:0] m_ctrl  [8];
  logic [2:0]  m_sel   [8];
  logic        m_arm   [8];
  logic [7:0]  m_stat, m_en;
  logic [31:0] m_snap, m_rdata;

  function automatic int basech(input int i);
    return (i < 4) ? 0 : ((i < 6) ? 4 : 6);
  endfunction

  function automatic int cmpch(input int i);
    return m_ctrl[i][7] ? i : basech(i);
  endfunction

  function automatic logic [31:0] rdreg(input logic [4:0] a);
    case (a[4:3])
      2'd0: return m_match[a[2:0]];
      2'd1: return m_cnt[a[2:0]];
      2'd2: return m_ctrl[a[2:0]];
      default: begin
        if (a[2:0] == 3'd0) return {24'd0, m_stat};
        if (a[2:0] == 3'd1) return {24'd0, m_en};
        if (a[2:0] == 3'd2) return m_snap;
        return 32'd0;
      end
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [7:0]  tk, ev, wc;
    logic [31:0] nc [8];
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_match[i] = '0; m_cnt[i] = '0; m_ctrl[i] = '0; m_sel[i] = '0; m_arm[i] = 1'b0;
      end
      m_stat = '0; m_en = '0; m_snap = '0; m_rdata = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        tk[i] = tick_src[m_sel[i]] && LIVE[m_sel[i]];
        wc[i] = wr_en && (addr == 5'(8 + i));
      end
      for (int i = 0; i < 8; i++) begin
        int c;
        c = cmpch(i);
        ev[i] = m_arm[i] && tk[c] && !wc[c] && ((m_cnt[c] + 32'd1) == m_match[i]);
      end
      if (rd_en) begin
        m_rdata = rdreg(addr);
        if ((addr == 5'd13 && m_ctrl[5][9]) || (addr == 5'd15 && m_ctrl[7][9]))
          m_snap = m_cnt[addr - 5'd9];
      end
      for (int i = 0; i < 8; i++) begin
        if (wc[i]) nc[i] = wdata;
        else if (tk[i])
          nc[i] = (ev[i] && cmpch(i) == i && m_ctrl[i][3]) ? 32'd0 : m_cnt[i] + 32'd1;
        else nc[i] = m_cnt[i];
      end
      if (wr_en && addr == 5'd24) m_stat = m_stat & ~wdata[7:0];
      m_stat = m_stat | (ev & m_en);
      if (wr_en && addr == 5'd25) m_en = wdata[7:0];
      for (int i = 0; i < 8; i++) begin
        if (wr_en && addr == 5'(i)) m_arm[i] = 1'b1;
        else if (ev[i] && !m_ctrl[i][6]) m_arm[i] = 1'b0;
        if (wr_en && addr == 5'(i)) m_match[i] = wdata;
        if (wr_en && addr == 5'(16 + i)) begin
          if (wdata[7] || i == 0 || i == 4 || i == 6)
            m_sel[i] = (i >= 4 && wdata[8]) ? 3'd0 : wdata[2:0];
          m_ctrl[i] = wdata & ((i < 4) ? 32'h0FF : 32'h3FF);
        end
        m_cnt[i] = nc[i];
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata === m_rdata, "rdata", rdata, m_rdata);
      chk(irq === (|m_stat), "irq", {31'd0, irq}, {31'd0, |m_stat});
    end
  end

  task automatic step(input bit w, input bit r, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    lfsr     = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
    wr_en    = w;
    rd_en    = r;
    addr     = a;
    wdata    = d;
    tick_src = rnd_t ? lfsr[7:0] : tmask;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d); step(1'b1, 1'b0, a, d); endtask
  task automatic rd(input logic [4:0] a);                       step(1'b0, 1'b1, a, '0); endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(rdata === 32'd0, "reset rdata", rdata, 32'd0);
    chk(irq === 1'b0, "reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 32; a++) rd(5'(a));

    cur_req = "R2";
    tmask = 8'h02; wr(5'd16, 32'h81); idle(6); rd(5'd8);
    tmask = 8'h22; wr(5'd16, 32'h85); idle(5); rd(5'd8);

    cur_req = "R4";
    wr(5'd17, 32'h003); tmask = 8'h08; idle(4); rd(5'd9);
    tmask = 8'h01; idle(3); rd(5'd9); rd(5'd17);

    cur_req = "R12";
    wr(5'd16, 32'h81); tmask = 8'h02; wr(5'd8, 32'hFFFF_FFFE); idle(4); rd(5'd8);

    cur_req = "R3";
    wr(5'd25, 32'hFF); wr(5'd8, 32'd0); wr(5'd1, 32'd10); idle(14); rd(5'd24);
    cur_req = "R10";
    wr(5'd24, 32'h01); idle(2); rd(5'd24); wr(5'd24, 32'h02); idle(2); rd(5'd24);

    cur_req = "R5";
    tmask = 8'h01; wr(5'd18, 32'hC8); wr(5'd2, 32'd5); idle(20); rd(5'd10); rd(5'd24);
    cur_req = "R11";
    wr(5'd24, 32'hFF); idle(8);
    cur_req = "R6";
    wr(5'd19, 32'h88); wr(5'd3, 32'd4); idle(20); rd(5'd24); wr(5'd24, 32'hFF); idle(10); rd(5'd24);

    cur_req = "R7";
    wr(5'd20, 32'h3FF); rd(5'd20); wr(5'd16, 32'h3FF); rd(5'd16);
    cur_req = "R8";
    wr(5'd20, 32'h187); tmask = 8'h01; idle(4); rd(5'd12);

    cur_req = "R9";
    wr(5'd20, 32'h81); tmask = 8'h02; idle(5); wr(5'd21, 32'h200);
    rd(5'd13); rd(5'd26); idle(3); rd(5'd26);
    wr(5'd21, 32'h000); idle(2); rd(5'd13); rd(5'd26);

    cur_req = "R14";
    wr(5'd22, 32'h81); wr(5'd22, 32'h82); idle(3); rd(5'd14);

    cur_req = "R13";
    rnd_t = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      d = lfsr[12] ? (lfsr & 32'h0000_03FF) : (lfsr & 32'h0000_003F);
      case (lfsr[21:20])
        2'd0: wr(lfsr[28:24], d);
        2'd1: rd(lfsr[28:24]);
        default: idle(1);
      endcase
    end
    rnd_t = 1'b0; tmask = '0;
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule